// File: doc/BRIEF.md
# Receive Frame Padding Aligner

This block sits behind a 10-gigabit receive MAC. It turns the MAC's 64-bit word interface into a 64-bit AXI4-Stream. The MAC interface carries start, end, error and valid strobes, plus a 3-bit count of the valid bytes in the final word. In front of every frame the block inserts six bytes. As a result, the protocol headers that follow the 14-byte Ethernet header start on a 4-byte boundary in downstream memory. The first inserted byte is a fixed label, set by a parameter, that names the ingress port. The other five inserted bytes are zero.

Every frame moves six bytes later in the stream, so the block recomputes the byte count of the final word. When the frame's tail no longer fits, the block emits one extra closing word. The MAC side has no backpressure. Any word the block cannot take is thrown away and counted, and the count is available on a port.

Byte order is big-endian within a word: the first byte of the stream is in bits [63:56].

Top module: `rx_pad_aligner`

## Requirements
- R1: After reset, `m_tvalid` is 0 and `drop_count` is 0.
- R2: The word that opens a frame (`in_sof` high) is emitted as `{PORT_LABEL, 40'h0, in_data[63:48]}`.
- R3: Every later word of a frame is emitted as the low 48 bits of the previous accepted input word, followed by bits [63:48] of the current word.
- R4: `in_occ` gives the valid bytes of the end word, with 0 meaning 8. When the end word holds 1 or 2 bytes, the output word built from it carries `m_tlast`, and `m_tuser[2:0]` is (`in_occ` + 6) mod 8, with 0 meaning 8.
- R5: When the end word holds 3 to 8 bytes, the next output word is `{last 48 bits of that input word, 16'h0}`. It carries `m_tlast`, and `m_tuser[2:0]` is (`in_occ` + 6) mod 8.
- R6: `m_tuser[3]` on the `m_tlast` word equals `in_err` of the end word. `m_tuser` is 0 on every word without `m_tlast`.
- R7: While `m_tvalid` is high and `m_tready` is low, `m_tvalid`, `m_tdata`, `m_tuser` and `m_tlast` keep their values.
- R8: An input word is taken only if the output register is empty or being consumed, and no extra closing word is waiting. Otherwise it is discarded, produces no output, and `drop_count` rises by one, saturating at its maximum.
- R9: A valid word that has no start flag and arrives outside an open frame is discarded and counted in `drop_count`.
- R10: A start flag inside an open frame abandons that frame without any `m_tlast` and opens a new one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_data | input | 64 | MAC receive word, first byte in [63:48] side |
| in_occ | input | 3 | Valid bytes in end word, 0 means 8 |
| in_sof | input | 1 | Word opens a frame |
| in_eof | input | 1 | Word ends a frame |
| in_err | input | 1 | Frame error flag, sampled with the end word |
| in_valid | input | 1 | Input word present |
| m_tdata | output | 64 | Stream data |
| m_tuser | output | 4 | [3] error, [2:0] last-word byte count |
| m_tlast | output | 1 | Final word of a frame |
| m_tvalid | output | 1 | Stream word valid |
| m_tready | input | 1 | Downstream accepts word |
| drop_count | output | 16 | Saturating count of discarded input words |

## Verification
The hardest case to reach is a word that arrives exactly when the extra closing word of the previous frame still owns the output. It is dropped even though the downstream sink is ready. The stimulus reaches it by ending a frame with a long tail and presenting a start word in the very next cycle. A second test uses the ports alone: the sink stalls right after the opening word, and the bench then offers a mid-frame word. That word must vanish from the stream, the frame must still close correctly, and the drop count must rise by one. Random sink stalls, with the driver watching `m_tvalid`, cover the holding behaviour.

// File: rtl/rx_pad_pkg.sv
package rx_pad_pkg;
  localparam int unsigned BYTE_W      = 8;
  localparam int unsigned WORD_BYTES  = 8;
  localparam int unsigned WORD_W      = WORD_BYTES * BYTE_W;
  localparam int unsigned OCC_W       = $clog2(WORD_BYTES);
  localparam int unsigned PAD_BYTES   = 6;
  localparam int unsigned CARRY_BYTES = WORD_BYTES - PAD_BYTES;
  localparam int unsigned PAD_W       = PAD_BYTES * BYTE_W;
  localparam int unsigned CARRY_W     = CARRY_BYTES * BYTE_W;
  localparam int unsigned USER_W      = OCC_W + 1;

  typedef struct packed {
    logic [WORD_W-1:0] data;
    logic [USER_W-1:0] user;
    logic              last;
  } beat_t;

  // byte count of the closing output word, wraps so 0 stands for a full word
  function automatic logic [OCC_W-1:0] tail_count(input logic [OCC_W-1:0] occ);
    return occ + OCC_W'(PAD_BYTES);
  endfunction

  // true when the frame tail no longer fits next to the carried bytes
  function automatic logic spills(input logic [OCC_W-1:0] occ);
    return (occ == '0) || (occ > OCC_W'(CARRY_BYTES));
  endfunction

  function automatic logic [WORD_W-1:0] head_word(input logic [BYTE_W-1:0] label,
                                                  input logic [WORD_W-1:0] cur);
    return {label, {(PAD_W - BYTE_W){1'b0}}, cur[WORD_W-1 -: CARRY_W]};
  endfunction

  function automatic logic [WORD_W-1:0] join_word(input logic [PAD_W-1:0]  prev,
                                                  input logic [WORD_W-1:0] cur);
    return {prev, cur[WORD_W-1 -: CARRY_W]};
  endfunction

  function automatic logic [WORD_W-1:0] flush_word(input logic [PAD_W-1:0] prev);
    return {prev, {CARRY_W{1'b0}}};
  endfunction
endpackage

// File: rtl/rx_pad_framer.sv
module rx_pad_framer
  import rx_pad_pkg::*;
#(
  parameter logic [BYTE_W-1:0] LABEL = 8'h00
)(
  input  logic              clk,
  input  logic              rst,
  input  logic [WORD_W-1:0] in_data,
  input  logic [OCC_W-1:0]  in_occ,
  input  logic              in_sof,
  input  logic              in_eof,
  input  logic              in_err,
  input  logic              in_valid,
  input  logic              slot_free,
  output beat_t             nxt,
  output logic              load,
  output logic              accept,
  output logic              drop,
  output logic              emit_extra,
  output logic              extra_pend
);
  logic              in_frame;
  logic [PAD_W-1:0]  carry_q;
  logic [OCC_W-1:0]  xcnt_q;
  logic              xerr_q;
  logic              take;

  assign take       = in_valid && slot_free && !extra_pend;
  assign accept     = take && (in_sof || in_frame);
  assign drop       = in_valid && !accept;
  assign emit_extra = extra_pend && slot_free;
  assign load       = accept || emit_extra;

  always_comb begin
    nxt = '0;
    if (emit_extra) begin
      nxt.data = flush_word(carry_q);
      nxt.user = {xerr_q, xcnt_q};
      nxt.last = 1'b1;
    end else begin
      nxt.data = in_sof ? head_word(LABEL, in_data) : join_word(carry_q, in_data);
      if (in_eof && !spills(in_occ)) begin
        nxt.last = 1'b1;
        nxt.user = {in_err, tail_count(in_occ)};
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      in_frame   <= 1'b0;
      extra_pend <= 1'b0;
      carry_q    <= '0;
      xcnt_q     <= '0;
      xerr_q     <= 1'b0;
    end else if (accept) begin
      carry_q  <= in_data[PAD_W-1:0];
      in_frame <= !in_eof;
      if (in_eof && spills(in_occ)) begin
        extra_pend <= 1'b1;
        xcnt_q     <= tail_count(in_occ);
        xerr_q     <= in_err;
      end
    end else if (emit_extra) begin
      extra_pend <= 1'b0;
    end
  end
endmodule

// File: rtl/rx_pad_outslot.sv
module rx_pad_outslot
  import rx_pad_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  beat_t             nxt,
  input  logic              m_tready,
  output logic [WORD_W-1:0] m_tdata,
  output logic [USER_W-1:0] m_tuser,
  output logic              m_tlast,
  output logic              m_tvalid,
  output logic              slot_free
);
  beat_t beat_q;
  logic  valid_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      beat_q  <= '0;
      valid_q <= 1'b0;
    end else if (load) begin
      beat_q  <= nxt;
      valid_q <= 1'b1;
    end else if (m_tready) begin
      valid_q <= 1'b0;
    end
  end

  assign slot_free = !valid_q || m_tready;
  assign m_tdata   = beat_q.data;
  assign m_tuser   = beat_q.user;
  assign m_tlast   = beat_q.last;
  assign m_tvalid  = valid_q;
endmodule

// File: rtl/rx_pad_dropcnt.sv
module rx_pad_dropcnt #(
  parameter int unsigned W   = 16,
  parameter bit          SAT = 1'b1
)(
  input  logic         clk,
  input  logic         rst,
  input  logic         drop,
  output logic [W-1:0] count
);
  generate
    if (SAT) begin : g_sat
      always_ff @(posedge clk) begin
        if (rst)                      count <= '0;
        else if (drop && count != '1) count <= count + W'(1);
      end
    end else begin : g_wrap
      always_ff @(posedge clk) begin
        if (rst)       count <= '0;
        else if (drop) count <= count + W'(1);
      end
    end
  endgenerate
endmodule

// File: rtl/rx_pad_aligner.sv
module rx_pad_aligner
  import rx_pad_pkg::*;
#(
  parameter logic [7:0]  PORT_LABEL = 8'h00,
  parameter int unsigned DROP_W     = 16,
  parameter bit          DROP_SAT   = 1'b1
)(
  input  logic              clk,
  input  logic              rst,
  input  logic [63:0]       in_data,
  input  logic [2:0]        in_occ,
  input  logic              in_sof,
  input  logic              in_eof,
  input  logic              in_err,
  input  logic              in_valid,
  output logic [63:0]       m_tdata,
  output logic [3:0]        m_tuser,
  output logic              m_tlast,
  output logic              m_tvalid,
  input  logic              m_tready,
  output logic [DROP_W-1:0] drop_count
);
  beat_t nxt;
  logic  load, accept, drop, emit_extra, extra_pend, slot_free;

  rx_pad_framer #(.LABEL(PORT_LABEL)) u_framer (
    .clk(clk), .rst(rst),
    .in_data(in_data), .in_occ(in_occ), .in_sof(in_sof), .in_eof(in_eof),
    .in_err(in_err), .in_valid(in_valid), .slot_free(slot_free),
    .nxt(nxt), .load(load), .accept(accept), .drop(drop),
    .emit_extra(emit_extra), .extra_pend(extra_pend)
  );

  rx_pad_outslot u_slot (
    .clk(clk), .rst(rst), .load(load), .nxt(nxt), .m_tready(m_tready),
    .m_tdata(m_tdata), .m_tuser(m_tuser), .m_tlast(m_tlast),
    .m_tvalid(m_tvalid), .slot_free(slot_free)
  );

  rx_pad_dropcnt #(.W(DROP_W), .SAT(DROP_SAT)) u_drops (
    .clk(clk), .rst(rst), .drop(drop), .count(drop_count)
  );
endmodule

// File: rtl/rx_pad_aligner_chk.sv
module rx_pad_aligner_chk #(
  parameter logic [7:0]  LABEL  = 8'h00,
  parameter int unsigned DROP_W = 16
)(
  input logic              clk,
  input logic              rst,
  input logic              in_sof,
  input logic              accept,
  input logic              drop,
  input logic              emit_extra,
  input logic              extra_pend,
  input logic [63:0]       m_tdata,
  input logic [3:0]        m_tuser,
  input logic              m_tlast,
  input logic              m_tvalid,
  input logic              m_tready,
  input logic [DROP_W-1:0] drop_count
);
  AST_PAD_HEAD: assert property (@(posedge clk) disable iff (rst)
    accept && in_sof |=> m_tvalid && m_tdata[63:56] == LABEL && m_tdata[55:16] == '0); // R2
  AST_EXTRA_IS_LAST: assert property (@(posedge clk) disable iff (rst)
    emit_extra |=> m_tvalid && m_tlast && m_tdata[15:0] == '0); // R5
  AST_USER_ZERO_MID: assert property (@(posedge clk) disable iff (rst)
    m_tvalid && !m_tlast |-> m_tuser == '0); // R6
  AST_HOLD_ON_STALL: assert property (@(posedge clk) disable iff (rst)
    m_tvalid && !m_tready |=> m_tvalid && $stable(m_tdata) && $stable(m_tuser) && $stable(m_tlast)); // R7
  AST_NO_TAKE_WHILE_PEND: assert property (@(posedge clk) disable iff (rst)
    extra_pend |-> !accept); // R8
  AST_DROP_COUNTS: assert property (@(posedge clk) disable iff (rst)
    drop && drop_count != '1 |=> drop_count == $past(drop_count) + DROP_W'(1)); // R8
  AST_QUIET_COUNT: assert property (@(posedge clk) disable iff (rst)
    !drop |=> $stable(drop_count)); // R8
endmodule

bind rx_pad_aligner rx_pad_aligner_chk #(.LABEL(PORT_LABEL), .DROP_W(DROP_W)) u_chk (
  .clk(clk), .rst(rst), .in_sof(in_sof), .accept(accept), .drop(drop),
  .emit_extra(emit_extra), .extra_pend(extra_pend),
  .m_tdata(m_tdata), .m_tuser(m_tuser), .m_tlast(m_tlast),
  .m_tvalid(m_tvalid), .m_tready(m_tready), .drop_count(drop_count)
);

// File: tb/tb_rx_pad_aligner.sv
`timescale 1ns/1ps
module tb_rx_pad_aligner;
  localparam logic [7:0] LABEL = 8'h5A;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [63:0] in_data = '0;
  logic [2:0]  in_occ = '0;
  logic        in_sof = 1'b0, in_eof = 1'b0, in_err = 1'b0, in_valid = 1'b0;
  logic [63:0] m_tdata;
  logic [3:0]  m_tuser;
  logic        m_tlast, m_tvalid;
  logic        m_tready = 1'b1;
  logic [15:0] drop_count;

  rx_pad_aligner #(.PORT_LABEL(LABEL)) dut (
    .clk(clk), .rst(rst), .in_data(in_data), .in_occ(in_occ), .in_sof(in_sof),
    .in_eof(in_eof), .in_err(in_err), .in_valid(in_valid),
    .m_tdata(m_tdata), .m_tuser(m_tuser), .m_tlast(m_tlast), .m_tvalid(m_tvalid),
    .m_tready(m_tready), .drop_count(drop_count)
  );

  always #2 clk = ~clk;

  logic [68:0] expq[$];
  logic [63:0] win[0:7];
  int nchk = 0, nfail = 0, mchk = 0, mfail = 0, cyc = 0;
  bit  stall_mode = 1'b0;
  logic [15:0] lfsr = 16'hACE1;

  always @(posedge clk) begin
    lfsr <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    cyc  <= cyc + 1;
    if (cyc > 150000) begin
      $display("FAIL watchdog expired actual=%0d expected<150000", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures",
               nchk + mchk + 1, nfail + mfail + 1);
      $finish;
    end
  end

  // scoreboard monitor: compares every handshaken word, and held words during stalls (R7)
  logic        stalled = 1'b0;
  logic [68:0] held;
  always @(negedge clk) begin
    if (!rst) begin
      if (stalled) begin
        mchk++;
        if (!(m_tvalid && {m_tlast, m_tuser, m_tdata} == held)) begin
          mfail++;
          $display("FAIL R7 hold actual=%h/%b expected=%h/1", {m_tlast, m_tuser, m_tdata}, m_tvalid, held);
        end
      end
      stalled = m_tvalid && !m_tready;
      held    = {m_tlast, m_tuser, m_tdata};
      if (m_tvalid && m_tready) begin
        mchk++;
        if (expq.size() == 0) begin
          mfail++;
          $display("FAIL R8 R9 unexpected word actual=%h expected=none", {m_tlast, m_tuser, m_tdata});
        end else begin
          logic [68:0] e;
          e = expq.pop_front();
          if ({m_tlast, m_tuser, m_tdata} != e) begin
            mfail++;
            $display("FAIL R2 R3 R4 R5 R6 stream word actual=%h expected=%h",
                     {m_tlast, m_tuser, m_tdata}, e);
          end
        end
      end
    end
  end

  task automatic check(input bit ok, input string tag, input logic [68:0] act, input logic [68:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // byte-stream model: label, five zeros, frame bytes, cut into big-endian words
  task automatic build(input int nw, input logic [2:0] occ, input bit err, input int seed, input bit complete);
    int n = (occ == 3'd0) ? 8 : int'(occ);
    int flen = complete ? 8 * (nw - 1) + n : 8 * nw;
    int slen = 6 + flen;
    int nout = complete ? (slen + 7) / 8 : nw;
    logic [7:0] fb[0:63];
    logic [7:0] st[0:79];
    for (int i = 0; i < 80; i++) st[i] = 8'h00;
    st[0] = LABEL;
    for (int i = 0; i < 64; i++) fb[i] = (i < flen) ? 8'(seed * 37 + i * 5 + 1) : 8'h00;
    for (int i = 0; i < flen; i++) st[6 + i] = fb[i];
    for (int k = 0; k < nw; k++)
      for (int b = 0; b < 8; b++) win[k][63 - 8 * b -: 8] = fb[8 * k + b];
    for (int j = 0; j < nout; j++) begin
      logic [63:0] w;
      logic        lf;
      logic [3:0]  u;
      for (int b = 0; b < 8; b++) w[63 - 8 * b -: 8] = st[8 * j + b];
      lf = complete && (j == nout - 1);
      u  = lf ? {err, 3'(slen % 8)} : 4'h0;
      expq.push_back({lf, u, w});
    end
  endtask

  task automatic put_word(input logic [63:0] d, input logic [2:0] o, input bit s, input bit e, input bit r);
    bit done = 1'b0;
    while (!done) begin
      @(posedge clk); #1;
      m_tready = stall_mode ? lfsr[0] : 1'b1;
      if (!m_tvalid || m_tready) begin
        in_data = d; in_occ = o; in_sof = s; in_eof = e; in_err = r; in_valid = 1'b1;
        done = 1'b1;
      end else begin
        in_valid = 1'b0;
      end
    end
  endtask

  task automatic drive(input int nw, input logic [2:0] occ, input bit err, input bit complete);
    for (int k = 0; k < nw; k++) begin
      bit last = complete && (k == nw - 1);
      put_word(win[k], last ? occ : 3'd0, k == 0, last, err && last);
    end
  endtask

  task automatic drain();
    do begin
      @(posedge clk); #1;
      in_valid = 1'b0; m_tready = 1'b1;
    end while (expq.size() != 0);
    repeat (2) @(posedge clk);
  endtask

  initial begin
    logic [15:0] dc0;
    repeat (4) @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    check(m_tvalid == 1'b0, "R1 tvalid after reset", 69'(m_tvalid), 69'(0));
    check(drop_count == 16'd0, "R1 drop_count after reset", 69'(drop_count), 69'(0));

    // R2 R3 R4 R5 R6: every end-word occupancy with 1..3 word frames, sink always ready
    for (int nw = 1; nw <= 3; nw++)
      for (int oc = 0; oc < 8; oc++) begin
        build(nw, 3'(oc), oc[0], nw * 10 + oc, 1'b1);
        drive(nw, 3'(oc), oc[0], 1'b1);
        drain();
      end

    // R7: random sink stalls on longer frames
    stall_mode = 1'b1;
    for (int f = 0; f < 12; f++) begin
      build(4 + f % 3, 3'(f), f[1], 100 + f, 1'b1);
      drive(4 + f % 3, 3'(f), f[1], 1'b1);
      drain();
    end
    stall_mode = 1'b0;

    // R8: word offered while output is stalled is dropped, frame still closes correctly
    build(3, 3'd5, 1'b0, 50, 1'b1);
    dc0 = drop_count;
    put_word(win[0], 3'd0, 1'b1, 1'b0, 1'b0);
    @(posedge clk); #1;
    m_tready = 1'b0;
    in_data = 64'hDEAD_BEEF_0BAD_F00D; in_sof = 1'b0; in_eof = 1'b0; in_valid = 1'b1;
    @(posedge clk); #1;
    in_valid = 1'b0;
    check(drop_count == dc0 + 16'd1, "R8 drop under stall", 69'(drop_count), 69'(dc0 + 16'd1));
    put_word(win[1], 3'd0, 1'b0, 1'b0, 1'b0);
    put_word(win[2], 3'd5, 1'b0, 1'b1, 1'b0);
    drain();

    // R8: start word right after a spilling end word collides with the extra word
    build(2, 3'd6, 1'b1, 60, 1'b1);
    dc0 = drop_count;
    drive(2, 3'd6, 1'b1, 1'b1);
    put_word(64'h1122_3344_5566_7788, 3'd0, 1'b1, 1'b0, 1'b0);
    @(posedge clk); #1;
    in_valid = 1'b0;
    check(drop_count == dc0 + 16'd1, "R8 drop while extra word pending", 69'(drop_count), 69'(dc0 + 16'd1));
    drain();
    repeat (3) @(posedge clk);
    check(expq.size() == 0, "R8 dropped start word produced no frame", 69'(expq.size()), 69'(0));

    // R9: orphan word outside any frame
    dc0 = drop_count;
    @(posedge clk); #1;
    in_data = 64'hCAFE_0000_CAFE_0000; in_sof = 1'b0; in_eof = 1'b1; in_occ = 3'd4; in_valid = 1'b1;
    @(posedge clk); #1;
    in_valid = 1'b0;
    check(drop_count == dc0 + 16'd1, "R9 orphan word counted", 69'(drop_count), 69'(dc0 + 16'd1));
    @(negedge clk);
    check(m_tvalid == 1'b0, "R9 orphan word not emitted", 69'(m_tvalid), 69'(0));

    // R10: start flag inside an open frame abandons it without tlast
    build(2, 3'd0, 1'b0, 70, 1'b0);
    drive(2, 3'd0, 1'b0, 1'b0);
    build(2, 3'd2, 1'b1, 80, 1'b1);
    drive(2, 3'd2, 1'b1, 1'b1);
    drain();
    check(expq.size() == 0, "R10 restart stream complete", 69'(expq.size()), 69'(0));

    $display("End of test - %0d assertions evaluated, %0d failures", nchk + mchk, nfail + mfail);
    $finish;
  end
endmodule